// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block turns the raw event sources of a UART into status bits and one interrupt line. Two of the sources come from FIFO fill levels. The receive source fires when the RX FIFO fills to a programmed fraction of its depth. The transmit source fires when the TX FIFO drains to a programmed fraction of its depth. The other five sources are pulses from the serial engines: receive timeout, framing error, parity error, break and overrun.

Every source has a sticky raw status bit. A mask register selects which raw bits reach the masked status. The interrupt line is the registered OR of the masked status. Software clears raw bits by writing ones to a clear register that cannot be read back. It sets the two thresholds through a level register.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted and at the first clock edge after release, the raw status, the masked status and `irq` are all zero. After reset the mask register is 0 and the level register is 0, so both thresholds are code 0.
- R2: A pulse on an event input sets its raw bit in the cycle that follows the pulse. The bits are timeout at 6, framing at 7, parity at 8, break at 9 and overrun at 10. The bit then stays set until it is cleared.
- R3: A `clr_we` cycle clears every raw bit whose `wdata` bit is 1. When a set condition and a clear hit the same bit in the same cycle, the set wins.
- R4: Raw bit 4 (RX) sets one cycle after `rx_count >= rx_threshold` becomes true. It stays set until cleared. It sets again only when the condition next goes from false to true.
- R5: Raw bit 5 (TX) sets one cycle after `tx_count <= tx_threshold` becomes true, and otherwise behaves like bit 4. Just after reset the condition counts as previously false.
- R6: A `lvl_we` cycle loads `wdata[2:0]` as the TX code and `wdata[5:3]` as the RX code. The new codes take effect from the next cycle. Codes 0, 1, 2, 3 and 4 select DEPTH×1/8, 2/8, 4/8, 6/8 and 7/8. Codes 5, 6 and 7 select DEPTH×4/8.
- R7: A `mask_we` cycle loads `wdata[10:4]` into the mask. `mask_stat` equals `raw_stat & mask`, where a mask bit of 1 enables its source.
- R8: `irq` is 1 exactly when the OR of `mask_stat` was 1 in the previous cycle.
- R9: Bits 3:0 of `raw_stat` and `mask_stat` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 6 | RX FIFO occupancy |
| tx_count | input | 6 | TX FIFO occupancy |
| ev_timeout | input | 1 | Receive timeout pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_break | input | 1 | Break error pulse |
| ev_overrun | input | 1 | Overrun error pulse |
| mask_we | input | 1 | Write strobe for the mask register |
| clr_we | input | 1 | Write strobe for the clear register |
| lvl_we | input | 1 | Write strobe for the level register |
| wdata | input | 11 | Write data shared by the three strobes |
| raw_stat | output | 11 | Raw status |
| mask_stat | output | 11 | Masked status |
| irq | output | 1 | Combined interrupt |

## Verification
A raw bit responds one cycle after its event, level crossing or clear. `mask_stat` follows a raw bit or a mask write within that same cycle. `irq` trails `mask_stat` by one more cycle. A level write changes the comparison only from the cycle after the write, so any crossing it causes shows in the raw bit one cycle later still. The bench keeps a reference model that it updates at each rising edge from the inputs alone. It drives the inputs 1 ns after the edge and compares every output at the falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH) + 1,
  parameter int SW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          ev_timeout,
  input  logic          ev_frame,
  input  logic          ev_parity,
  input  logic          ev_break,
  input  logic          ev_overrun,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic          lvl_we,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] raw_stat,
  output logic [SW-1:0] mask_stat,
  output logic          irq
);
  localparam int LO = 4;
  localparam int NB = SW - LO;

  function automatic logic [CW-1:0] thr_of(input logic [2:0] code);
    int k;
    case (code)
      3'd0:    k = 1;
      3'd1:    k = 2;
      3'd3:    k = 6;
      3'd4:    k = 7;
      default: k = 4;
    endcase
    return CW'((DEPTH * k) / 8);
  endfunction

  logic [NB-1:0] raw_q, mask_q, set_v, clr_v;
  logic [2:0]    tx_code, rx_code;
  logic          rx_prev, tx_prev, rx_cond, tx_cond;

  assign rx_cond = rx_count >= thr_of(rx_code);
  assign tx_cond = tx_count <= thr_of(tx_code);
  assign set_v   = {ev_overrun, ev_break, ev_parity, ev_frame, ev_timeout,
                    tx_cond & ~tx_prev, rx_cond & ~rx_prev};
  assign clr_v   = clr_we ? wdata[SW-1:LO] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      tx_code <= '0;
      rx_code <= '0;
      rx_prev <= 1'b0;
      tx_prev <= 1'b0;
      irq     <= 1'b0;
    end else begin
      raw_q   <= set_v | (raw_q & ~clr_v);
      rx_prev <= rx_cond;
      tx_prev <= tx_cond;
      irq     <= |(raw_q & mask_q);
      if (mask_we) mask_q <= wdata[SW-1:LO];
      if (lvl_we) begin
        tx_code <= wdata[2:0];
        rx_code <= wdata[5:3];
      end
    end
  end

  assign raw_stat  = {raw_q, {LO{1'b0}}};
  assign mask_stat = {raw_q & mask_q, {LO{1'b0}}};

  generate
    for (genvar i = 2; i < NB; i++) begin : g_err
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[LO+i] && !(clr_we && wdata[LO+i])) |=> raw_stat[LO+i]);
    end
  endgenerate

  a_r2_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> raw_stat[7]);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[8] && !ev_parity) |=> !raw_stat[8]);
  a_r4_rx_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cond && !rx_prev) |=> raw_stat[4]);
  a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|mask_stat));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
  localparam int DEPTH = 32;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] rx_count = 0, tx_count = 0;
  logic ev_timeout = 0, ev_frame = 0, ev_parity = 0, ev_break = 0, ev_overrun = 0;
  logic mask_we = 0, clr_we = 0, lvl_we = 0;
  logic [10:0] wdata = 0;
  logic [10:0] raw_stat, mask_stat;
  logic irq;

  uart_irq_ctrl dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [10:0] m_raw = 0, m_mask = 0;
  logic m_irq = 0, m_rxp = 0, m_txp = 0;
  int m_txc = 0, m_rxc = 0;

  function automatic int thr(input int code);
    if (code == 0) return DEPTH / 8;
    if (code == 1) return DEPTH / 4;
    if (code == 3) return DEPTH * 3 / 4;
    if (code == 4) return DEPTH * 7 / 8;
    return DEPTH / 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = 0; m_mask = 0; m_irq = 0; m_rxp = 0; m_txp = 0; m_txc = 0; m_rxc = 0;
    end else begin
      logic rxc, txc;
      logic [10:0] nr;
      rxc = int'(rx_count) >= thr(m_rxc);
      txc = int'(tx_count) <= thr(m_txc);
      m_irq = |(m_raw & m_mask);
      nr = m_raw;
      if (clr_we) nr = nr & ~wdata & 11'h7F0;
      if (rxc && !m_rxp) nr[4] = 1;
      if (txc && !m_txp) nr[5] = 1;
      if (ev_timeout) nr[6] = 1;
      if (ev_frame)   nr[7] = 1;
      if (ev_parity)  nr[8] = 1;
      if (ev_break)   nr[9] = 1;
      if (ev_overrun) nr[10] = 1;
      m_raw = nr;
      m_rxp = rxc; m_txp = txc;
      if (mask_we) m_mask = wdata & 11'h7F0;
      if (lvl_we) begin m_txc = int'(wdata[2:0]); m_rxc = int'(wdata[5:3]); end
    end
  end

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R4 rx bit", {10'd0, raw_stat[4]}, {10'd0, m_raw[4]});
    chk("R5 tx bit", {10'd0, raw_stat[5]}, {10'd0, m_raw[5]});
    chk("R2/R3 error bits", raw_stat & 11'h7C0, m_raw & 11'h7C0);
    chk("R9 low bits", {raw_stat[3:0], mask_stat[3:0]}, 11'd0);
    chk("R7 masked", mask_stat, m_raw & m_mask);
    chk("R8 irq", {10'd0, irq}, {10'd0, m_irq});
    if (!rst_n) chk("R1 reset", {raw_stat[10:1] | mask_stat[10:1], irq}, 11'd0);
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
    mask_we = 0; clr_we = 0; lvl_we = 0;
    {ev_timeout, ev_frame, ev_parity, ev_break, ev_overrun} = '0;
  endtask

  task automatic wr(input int kind, input logic [10:0] d);
    wdata = d;
    if (kind == 0) mask_we = 1; else if (kind == 1) clr_we = 1; else lvl_we = 1;
    step();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    tx_count = 20;
    step(2);
    wr(0, 11'h7F0);                  // R7 enable all
    wr(2, {5'd0, 3'd2, 3'd1});       // R6 rx code 2 -> 16, tx code 1 -> 8
    for (int i = 0; i <= 20; i++) begin rx_count = CW'(i); step(); end  // R4
    wr(1, 11'h010);                  // R3 clear rx bit
    step(3);
    for (int i = 20; i >= 3; i--) begin tx_count = CW'(i); step(); end  // R5
    ev_frame = 1; step(); ev_parity = 1; ev_break = 1; step(2); // R2
    ev_overrun = 1; wdata = 11'h7F0; clr_we = 1; step();        // R3 set wins
    wr(1, 11'h7F0);
    wr(2, {5'd0, 3'd6, 3'd7});       // R6 reserved codes -> 16
    rx_count = 0; tx_count = 30; step(2);
    rx_count = 16; tx_count = 16; step(3);
    wr(0, 11'h0C0);                  // R7 partial mask
    ev_timeout = 1; step(3);
    wr(2, {5'd0, 3'd4, 3'd3});       // R6 codes 4 and 3
    for (int c = 0; c < 3000; c++) begin
      rx_count = CW'($urandom_range(0, 32));
      tx_count = CW'($urandom_range(0, 32));
      {ev_timeout, ev_frame, ev_parity, ev_break, ev_overrun} = 5'($urandom) & 5'($urandom);
      if ($urandom_range(0, 7) == 0) begin wdata = 11'($urandom); clr_we = 1; end
      else if ($urandom_range(0, 15) == 0) begin wdata = 11'($urandom); mask_we = 1; end
      else if ($urandom_range(0, 31) == 0) begin wdata = 11'($urandom); lvl_we = 1; end
      step();
    end
    rst_n = 0; step(2);              // R1 reset mid-run
    rst_n = 1; step(2);
    finish_run();
  end
endmodule